// File: doc/BRIEF.md
# Memory Refresh Row Counter

This block keeps the 8-bit refresh row register of a small 8-bit processor core. It produces the row address that dynamic memory needs during every instruction fetch. The register advances by one on each opcode-fetch machine cycle. The advance happens on the clock edge that ends the second clock state of that fetch. Only the seven low bits count. The top bit keeps its value until software writes the whole register.

In the back half of a fetch, the block asserts an active-low refresh strobe. It also places a 16-bit address on its output: the page register value forms the upper byte and the refresh register forms the lower byte. The page register is a separate 8-bit store with its own write strobe. Outside that window the strobe is high and the address output is all zeros, so a bus mux can OR it in without effect. The surrounding core drives the fetch flag and the clock-state code, and uses the read value for its register-transfer path.

Top module: `rfa_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cnt_q`, the page register, `rf_addr` and the inactive `rf_strobe_n` (1) all read zero/inactive. An asynchronous reset clears a page value that was written earlier.
- R2: A clock edge advances the low seven bits of the refresh register by one when `fetch_cyc` is 1, `tstate` is 2 (encoding: 1 to 4 select the first to fourth clock state, 0 is idle) and no load occurs. The new value is visible on `cnt_q` in the cycle that follows, which is clock state 3 of the same fetch.
- R3: An advance never alters bit 7 of the refresh register.
- R4: The low seven bits wrap from 7Fh to 00h while bit 7 is kept, so FFh steps to 80h and 7Fh steps to 00h.
- R5: `cnt_ld` high at a clock edge writes all eight bits of `cnt_din`, including bit 7, into the register. The value is visible on `cnt_q` after that edge.
- R6: When a load and an advance fall on the same edge, the loaded value is stored and no advance is applied.
- R7: `rf_strobe_n` is 0 exactly when `fetch_cyc` is 1 and `tstate` is 3 or 4, and is 1 otherwise.
- R8: While `rf_strobe_n` is 0, `rf_addr[15:8]` equals the page register and `rf_addr[7:0]` equals `cnt_q`. While `rf_strobe_n` is 1, `rf_addr` is 0000h.
- R9: `pg_we` high at a clock edge stores `pg_din` in the page register. The new page appears in the upper address byte of the next refresh window.
- R10: Without a load, the register holds its value on every edge that is not a fetch in clock state 2. This covers `tstate` of 2 with `fetch_cyc` at 0, and clock states 1, 3 and 4 of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_cyc | input | 1 | High throughout an opcode-fetch machine cycle |
| tstate | input | 3 | Clock state code within the machine cycle (0 idle, 1 to 4) |
| cnt_ld | input | 1 | Write strobe for the refresh register |
| cnt_din | input | 8 | Value written on `cnt_ld` |
| pg_we | input | 1 | Write strobe for the page register |
| pg_din | input | 8 | Value written on `pg_we` |
| cnt_q | output | 8 | Current refresh register value |
| rf_addr | output | 16 | Refresh address; zero outside the refresh window |
| rf_strobe_n | output | 1 | Refresh strobe, active low |

## Verification
The main counting function is driven in four ways.
- Back-to-back fetches from a cleared register show the basic one-step advance.
- Runs started from 7Eh and FDh take the count across the seven-bit wrap with bit 7 clear and then set, which separates a seven-bit wrap from an eight-bit one.
- A load placed on the advancing edge shows which of the two wins.
- Fetch flags without clock state 2, and clock state 2 without the fetch flag, show that no other cycle advances the count.

A long pseudo-random stream of mixed fetches, loads and page writes is then compared on every clock against a behavioural model.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
   localparam int TS_W = 3;
   typedef enum logic [TS_W-1:0] {
      TS_IDLE = 3'd0,
      TS_T1   = 3'd1,
      TS_T2   = 3'd2,
      TS_T3   = 3'd3,
      TS_T4   = 3'd4
   } tstate_e;
endpackage

// File: rtl/rfa_counter.sv
module rfa_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q
);
   localparam int LW = W - 1;

   if (W < 2) begin : g_bad_w
      $error("rfa_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (ld)
         q <= ld_val;
      else if (adv)
         q <= {q[W-1], q[LW-1:0] + 1'b1};
   end

   // R2
   low_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld) |=> (q[LW-1:0] == LW'($past(q[LW-1:0]) + 1'b1)));
   // R3
   msb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld) |=> (q[W-1] == $past(q[W-1])));
   // R6
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (q == $past(ld_val)));
   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !ld) |=> $stable(q));
endmodule

// File: rtl/rfa_page.sv
module rfa_page #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("rfa_page: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (we)
         q <= din;
   end

   // R9
   pg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(din)));
   // R9
   pg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/rfa_bus.sv
module rfa_bus
   import rfa_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int PAGE_W = 8
) (
   input  logic                    fetch_cyc,
   input  logic [TS_W-1:0]         tstate,
   input  logic [CNT_W-1:0]        cnt,
   input  logic [PAGE_W-1:0]       page,
   output logic [PAGE_W+CNT_W-1:0] addr,
   output logic                    strobe_n
);
   logic win;

   always_comb begin
      win = fetch_cyc && ((tstate == TS_T3) || (tstate == TS_T4));
   end

   for (genvar i = 0; i < PAGE_W + CNT_W; i++) begin : g_bit
      if (i < CNT_W) begin : g_lo
         assign addr[i] = win & cnt[i];
      end else begin : g_hi
         assign addr[i] = win & page[i-CNT_W];
      end
   end

   assign strobe_n = ~win;
endmodule

// File: rtl/rfa_top.sv
module rfa_top
   import rfa_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_cyc,
   input  logic [TS_W-1:0]   tstate,
   input  logic              cnt_ld,
   input  logic [CNT_W-1:0]  cnt_din,
   input  logic              pg_we,
   input  logic [ADDR_W-CNT_W-1:0] pg_din,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [ADDR_W-1:0] rf_addr,
   output logic              rf_strobe_n
);
   localparam int PAGE_W = ADDR_W - CNT_W;

   if (ADDR_W <= CNT_W) begin : g_bad_aw
      $error("rfa_top: ADDR_W must exceed CNT_W");
   end

   logic              adv;
   logic [PAGE_W-1:0] page_q;

   assign adv = fetch_cyc && (tstate == TS_T2);

   rfa_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(adv), .ld(cnt_ld),
      .ld_val(cnt_din), .q(cnt_q)
   );

   rfa_page #(.W(PAGE_W)) u_pg (
      .clk(clk), .rst_n(rst_n), .we(pg_we), .din(pg_din), .q(page_q)
   );

   rfa_bus #(.CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_bus (
      .fetch_cyc(fetch_cyc), .tstate(tstate), .cnt(cnt_q), .page(page_q),
      .addr(rf_addr), .strobe_n(rf_strobe_n)
   );

   // R7
   strobe_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_strobe_n |-> (fetch_cyc && (tstate == TS_T3 || tstate == TS_T4)));
   // R7
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_cyc && tstate == TS_T3) |-> !rf_strobe_n);
   // R8
   addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_strobe_n |-> (rf_addr == '0));
   // R8
   addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_strobe_n |-> (rf_addr[CNT_W-1:0] == cnt_q));
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (cnt_q == '0 && rf_addr == '0));
endmodule

// File: tb/sim_rfa_top.sv
`timescale 1ns/1ps
module sim_rfa_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_cyc = 1'b0;
   logic [2:0]  tstate = 3'd0;
   logic        cnt_ld = 1'b0;
   logic [7:0]  cnt_din = 8'd0;
   logic        pg_we = 1'b0;
   logic [7:0]  pg_din = 8'd0;
   logic [7:0]  cnt_q;
   logic [15:0] rf_addr;
   logic        rf_strobe_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int ref_r = 0;
   int ref_pg = 0;

   always #2.5 clk = ~clk;

   rfa_top u0 (
      .clk(clk), .rst_n(rst_n), .fetch_cyc(fetch_cyc), .tstate(tstate),
      .cnt_ld(cnt_ld), .cnt_din(cnt_din), .pg_we(pg_we), .pg_din(pg_din),
      .cnt_q(cnt_q), .rf_addr(rf_addr), .rf_strobe_n(rf_strobe_n)
   );

   task automatic chk(input int act, input int exp, input string tag, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at falling edge, compare, then advance the model at rising edge
   task automatic cyc(input bit f, input int t, input bit ld, input int lv,
                      input bit pw, input int pv, input string tag);
      bit win;
      @(negedge clk);
      fetch_cyc = f; tstate = 3'(t); cnt_ld = ld; cnt_din = 8'(lv);
      pg_we = pw; pg_din = 8'(pv);
      #1;
      win = f && (t == 3 || t == 4);
      chk(int'(cnt_q), ref_r, tag, "cnt_q");
      chk(int'(rf_strobe_n), win ? 0 : 1, "R7", "strobe");
      chk(int'(rf_addr), win ? (ref_pg * 256 + ref_r) : 0, "R8", "addr");
      @(posedge clk);
      if (ld) ref_r = lv & 255;
      else if (f && t == 2) ref_r = (ref_r & 128) | ((ref_r + 1) & 127);
      if (pw) ref_pg = pv & 255;
   endtask

   task automatic fetch(input string tag);
      for (int t = 1; t <= 4; t++) cyc(1, t, 0, 0, 0, 0, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; fetch_cyc = 0; tstate = 0; cnt_ld = 0; pg_we = 0;
      #1;
      ref_r = 0; ref_pg = 0;
      chk(int'(cnt_q), 0, "R1", "cnt_q in reset");
      chk(int'(rf_addr), 0, "R1", "addr in reset");
      chk(int'(rf_strobe_n), 1, "R1", "strobe in reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      int lfsr;
      do_reset();
      cyc(0, 0, 0, 0, 0, 0, "R1");
      // page and count written, then a second reset must clear both
      cyc(0, 0, 1, 8'h33, 1, 8'h5A, "R5");
      cyc(0, 0, 0, 0, 0, 0, "R5");
      fetch("R1");
      do_reset();
      cyc(0, 0, 0, 0, 0, 0, "R1");
      fetch("R1");   // window shows page 00, count 01
      chk(int'(cnt_q), 1, "R1", "count after first fetch");
      // R2 plain advance
      repeat (5) fetch("R2");
      chk(int'(cnt_q), 6, "R2", "count after six fetches");
      // R4 wrap with bit 7 clear
      cyc(0, 0, 1, 8'h7E, 0, 0, "R5");
      repeat (2) fetch("R4");
      chk(int'(cnt_q), 8'h00, "R4", "7F to 00");
      // R3 / R4 with bit 7 set
      cyc(0, 0, 1, 8'hFD, 0, 0, "R5");
      repeat (3) fetch("R3");
      chk(int'(cnt_q), 8'h80, "R3", "FF to 80 keeps bit 7");
      // R6 load on the advancing edge
      cyc(1, 1, 0, 0, 0, 0, "R6");
      cyc(1, 2, 1, 8'h44, 0, 0, "R6");
      cyc(1, 3, 0, 0, 0, 0, "R6");
      chk(int'(cnt_q), 8'h44, "R6", "load beats advance");
      cyc(1, 4, 0, 0, 0, 0, "R6");
      // R10 no advance outside fetch state 2
      repeat (3) cyc(0, 2, 0, 0, 0, 0, "R10");
      cyc(1, 1, 0, 0, 0, 0, "R10");
      cyc(1, 3, 0, 0, 0, 0, "R10");
      cyc(1, 4, 0, 0, 0, 0, "R10");
      cyc(1, 0, 0, 0, 0, 0, "R10");
      chk(int'(cnt_q), 8'h44, "R10", "held value");
      // R9 page write shows in next window
      cyc(0, 0, 0, 0, 1, 8'hC3, "R9");
      fetch("R9");
      cyc(1, 3, 0, 0, 0, 0, "R9");
      #1 chk(int'(rf_addr), 16'hC345, "R9", "page in upper byte");
      // mixed stream against the model
      lfsr = 32'h1ACE5;
      for (int i = 0; i < 400; i++) begin
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB4BCD35C : 0);
         cyc(lfsr[0] | lfsr[1], (lfsr >> 2) % 5, (lfsr[7:4] == 4'h0),
             (lfsr >> 8) & 255, (lfsr[19:16] == 4'h0), (lfsr >> 20) & 255, "R2");
      end
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule